// File: doc/BRIEF.md
# Prioritised Interrupt Acceptance and Dispatch

This block sits between the interrupt delivery fabric and a processor core. Each incoming request carries an 8-bit vector, a 3-bit delivery mode and a trigger type (level or edge). Fixed and lowest-priority requests are queued in a 256-bit request register, with one bit per vector and a matching trigger bit. System-management, non-maskable, init and external requests each latch their own pending flag and vector.

From this state the block decides, every cycle, whether to raise its pending line toward the core and which interrupt to present. Unmaskable classes ignore the core's interrupt-enable flag. External and queued interrupts wait for it. A queued vector must also outrank both the highest vector already in service and the priority class held in the task-priority input.

When the core acknowledges, the presented interrupt is consumed. A queued vector moves from the request register into a 256-bit in-service register. Any other class just drops its flag. An end-of-interrupt pulse retires the highest vector in service.

Top module: `irq_dispatch`

## Requirements
- R1: After reset the request, trigger and in-service registers and all class flags are empty, so `irq_pending`=0, `irq_kind`=0, `irq_vector`=0 and `irq_level`=0.
- R2: A request with mode 0 (fixed) or 1 (lowest-priority) sets the request bit of its vector. When that bit was clear, the trigger bit is set for `req_level`=1 and cleared for `req_level`=0. While that vector is presented, `irq_level` shows its trigger bit.
- R3: A queued request whose vector bit is already set changes neither the request bit nor the trigger bit.
- R4: Mode 2 (system-management), 4 (non-maskable), 5 (init) and 7 (external) each latch their own flag and vector, but only while that flag is clear. A repeat while the flag is set keeps the first vector.
- R5: Modes 3 and 6 are reserved and change no state.
- R6: A pending system-management, non-maskable or init flag raises `irq_pending` whatever `int_enable` is. External and queued interrupts are presented only while `int_enable`=1.
- R7: A queued interrupt is presented only when the highest requested vector is greater than the highest in-service vector, and its bits 7:4 are greater than `task_prio` bits 7:4.
- R8: Presentation order is system-management (kind 1), then non-maskable (2), then init (3), then external (4), then the highest queued vector (5). Kind 0 means nothing is presented.
- R9: Acknowledging a queued interrupt sets its in-service bit and clears its request bit. The next highest request is then considered.
- R10: End-of-interrupt clears the in-service bit of the highest vector in service, so lower in-service vectors then gate requests.
- R11: Acknowledging a system-management, non-maskable, init or external interrupt clears only that class's flag and leaves the in-service register unchanged.
- R12: `ack` while `irq_pending`=0 changes no state.
- R13: An empty register counts as vector 0, so a queued request for vector 0 is never presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_vector | input | 8 | Request vector |
| req_mode | input | 3 | Delivery mode code |
| req_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| int_enable | input | 1 | Core interrupt-enable flag |
| task_prio | input | 8 | Task priority; bits 7:4 form the class threshold |
| ack | input | 1 | Core takes the presented interrupt |
| eoi | input | 1 | End of interrupt for the highest in-service vector |
| irq_pending | output | 1 | An interrupt is presented to the core |
| irq_kind | output | 3 | Class of the presented interrupt |
| irq_vector | output | 8 | Vector of the presented interrupt |
| irq_level | output | 1 | Trigger bit of a presented queued vector |

## Verification
The embedded properties check the cycle-level rules on every clock:
- unmaskable flags always raise the pending line, and external and queued interrupts stay silent while disabled;
- a presented queued vector always clears the in-service and task-priority thresholds, and a system-management flag always wins the order;
- an acknowledged queued vector lands in service, and end-of-interrupt removes the top in-service bit;
- duplicate requests leave trigger bits alone, and acknowledging a non-queued class leaves the in-service register alone.

Only the directed scenarios can show sequence-level outcomes:
- the full ranking, as five classes are drained one acknowledge at a time;
- a repeated class request keeping its first vector;
- in-service vectors blocking lower requests until successive end-of-interrupt pulses release them;
- reserved modes, idle acknowledges and vector 0 leaving no trace.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

    localparam int NUM_VEC   = 256;
    localparam int VEC_W     = $clog2(NUM_VEC);
    localparam int PRIO_W    = 4;
    localparam int NUM_CLASS = 4;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSV3   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_RSV6   = 3'd6,
        DM_EXT    = 3'd7
    } dmode_e;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_SMI   = 3'd1,
        K_NMI   = 3'd2,
        K_INIT  = 3'd3,
        K_EXT   = 3'd4,
        K_FIXED = 3'd5
    } kind_e;

    // class slots, in presentation order
    localparam int CL_SMI  = 0;
    localparam int CL_NMI  = 1;
    localparam int CL_INIT = 2;
    localparam int CL_EXT  = 3;

    function automatic logic [2:0] class_mode(input int slot);
        unique case (slot)
            CL_SMI:  class_mode = DM_SMI;
            CL_NMI:  class_mode = DM_NMI;
            CL_INIT: class_mode = DM_INIT;
            default: class_mode = DM_EXT;
        endcase
    endfunction

    function automatic logic is_queued_mode(input logic [2:0] mode);
        is_queued_mode = (mode == DM_FIXED) || (mode == DM_LOWEST);
    endfunction

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int WIDTH = 256,
    localparam int IDXW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] bits_in,
    output logic [IDXW-1:0]  top_idx,
    output logic             any_set
);
    // Highest set bit wins; an empty input reports index 0.
    always_comb begin
        top_idx = '0;
        any_set = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (bits_in[i]) begin
                top_idx = IDXW'(i);
                any_set = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_bitvec_reg.sv
module irq_bitvec_reg #(
    parameter int WIDTH = 256,
    localparam int IDXW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDXW-1:0]  set_idx,
    input  logic             clr_en,
    input  logic [IDXW-1:0]  clr_idx,
    output logic [WIDTH-1:0] bits_q
);
    logic [WIDTH-1:0] bits_d;

    always_comb begin
        bits_d = bits_q;
        if (clr_en) bits_d[clr_idx] = 1'b0;
        if (set_en) bits_d[set_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> bits_q[$past(set_idx)]);
endmodule

// File: rtl/irq_flag_latch.sv
module irq_flag_latch #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [VEC_W-1:0] hit_vec,
    input  logic             take,
    output logic             pend_q,
    output logic [VEC_W-1:0] vec_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            vec_q  <= '0;
        end else if (hit && !pend_q) begin
            pend_q <= 1'b1;
            vec_q  <= hit_vec;
        end else if (take) begin
            pend_q <= 1'b0;
        end
    end

    assert_first_vec_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !take) |=> (pend_q && $stable(vec_q)));

    assert_take_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pend_q) |=> !pend_q);
endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_dispatch_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CLASS-1:0]       cls_pend,
    input  logic [NUM_CLASS*VEC_W-1:0] cls_vecs,
    input  logic                       irr_any,
    input  logic [VEC_W-1:0]           irr_top,
    input  logic [VEC_W-1:0]           isr_top,
    input  logic                       int_enable,
    input  logic [VEC_W-1:0]           task_prio,
    input  logic                       ack,
    output logic                       present,
    output kind_e                      kind,
    output logic [VEC_W-1:0]           vec_out,
    output logic [NUM_CLASS-1:0]       take_cls,
    output logic                       take_fixed
);
    logic unmaskable;
    logic fixed_ok;
    logic take;
    logic unused_tpr_low;

    assign unused_tpr_low = ^task_prio[VEC_W-PRIO_W-1:0];
    assign unmaskable = cls_pend[CL_SMI] | cls_pend[CL_NMI] | cls_pend[CL_INIT];
    assign fixed_ok = irr_any && (irr_top > isr_top) &&
                      (irr_top[VEC_W-1 -: PRIO_W] > task_prio[VEC_W-1 -: PRIO_W]);

    // ranking
    always_comb begin
        if (cls_pend[CL_SMI])                     kind = K_SMI;
        else if (cls_pend[CL_NMI])                kind = K_NMI;
        else if (cls_pend[CL_INIT])               kind = K_INIT;
        else if (int_enable && cls_pend[CL_EXT])  kind = K_EXT;
        else if (int_enable && fixed_ok)          kind = K_FIXED;
        else                                      kind = K_NONE;
    end

    assign present = (kind != K_NONE);
    assign take    = ack && present;

    // output and acknowledge decode
    always_comb begin
        take_cls   = '0;
        take_fixed = 1'b0;
        vec_out    = '0;
        unique case (kind)
            K_SMI: begin
                vec_out          = cls_vecs[CL_SMI*VEC_W +: VEC_W];
                take_cls[CL_SMI] = take;
            end
            K_NMI: begin
                vec_out          = cls_vecs[CL_NMI*VEC_W +: VEC_W];
                take_cls[CL_NMI] = take;
            end
            K_INIT: begin
                vec_out           = cls_vecs[CL_INIT*VEC_W +: VEC_W];
                take_cls[CL_INIT] = take;
            end
            K_EXT: begin
                vec_out          = cls_vecs[CL_EXT*VEC_W +: VEC_W];
                take_cls[CL_EXT] = take;
            end
            K_FIXED: begin
                vec_out    = irr_top;
                take_fixed = take;
            end
            default: begin
                vec_out = '0;
            end
        endcase
    end

    assert_unmaskable_shown_R6: assert property (@(posedge clk) disable iff (!rst_n)
        unmaskable |-> present);

    assert_enable_gates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_enable && !unmaskable) |-> !present);

    assert_fixed_thresholds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_FIXED) |-> ((irr_top > isr_top) &&
            (irr_top[VEC_W-1 -: PRIO_W] > task_prio[VEC_W-1 -: PRIO_W])));

    assert_smi_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cls_pend[CL_SMI] |-> (kind == K_SMI));

    assert_idle_ack_inert_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !present |-> (take_cls == '0 && !take_fixed));
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irq_dispatch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [7:0] req_vector,
    input  logic [2:0] req_mode,
    input  logic       req_level,
    input  logic       int_enable,
    input  logic [7:0] task_prio,
    input  logic       ack,
    input  logic       eoi,
    output logic       irq_pending,
    output logic [2:0] irq_kind,
    output logic [7:0] irq_vector,
    output logic       irq_level
);
    logic [NUM_VEC-1:0]         irr_bits;
    logic [NUM_VEC-1:0]         trig_bits;
    logic [NUM_VEC-1:0]         isr_bits;
    logic [VEC_W-1:0]           irr_top;
    logic [VEC_W-1:0]           isr_top;
    logic                       irr_any;
    logic                       isr_any;
    logic                       queued_req;
    logic                       irr_new;
    logic [NUM_CLASS-1:0]       cls_pend;
    logic [NUM_CLASS*VEC_W-1:0] cls_vecs;
    logic [NUM_CLASS-1:0]       take_cls;
    logic                       take_fixed;
    kind_e                      kind;

    assign queued_req = req_valid && is_queued_mode(req_mode);
    assign irr_new    = queued_req && !irr_bits[req_vector];

    irq_bitvec_reg #(.WIDTH(NUM_VEC)) u_request (
        .clk(clk), .rst_n(rst_n),
        .set_en(irr_new), .set_idx(req_vector),
        .clr_en(take_fixed), .clr_idx(irr_top),
        .bits_q(irr_bits)
    );

    irq_bitvec_reg #(.WIDTH(NUM_VEC)) u_trigger (
        .clk(clk), .rst_n(rst_n),
        .set_en(irr_new && req_level), .set_idx(req_vector),
        .clr_en(irr_new && !req_level), .clr_idx(req_vector),
        .bits_q(trig_bits)
    );

    irq_bitvec_reg #(.WIDTH(NUM_VEC)) u_service (
        .clk(clk), .rst_n(rst_n),
        .set_en(take_fixed), .set_idx(irr_top),
        .clr_en(eoi), .clr_idx(isr_top),
        .bits_q(isr_bits)
    );

    irq_prio_enc #(.WIDTH(NUM_VEC)) u_irr_enc (
        .bits_in(irr_bits), .top_idx(irr_top), .any_set(irr_any)
    );

    irq_prio_enc #(.WIDTH(NUM_VEC)) u_isr_enc (
        .bits_in(isr_bits), .top_idx(isr_top), .any_set(isr_any)
    );

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        irq_flag_latch #(.VEC_W(VEC_W)) u_flag (
            .clk(clk), .rst_n(rst_n),
            .hit(req_valid && (req_mode == class_mode(c))),
            .hit_vec(req_vector),
            .take(take_cls[c]),
            .pend_q(cls_pend[c]),
            .vec_q(cls_vecs[c*VEC_W +: VEC_W])
        );
    end

    irq_select u_select (
        .clk(clk), .rst_n(rst_n),
        .cls_pend(cls_pend), .cls_vecs(cls_vecs),
        .irr_any(irr_any), .irr_top(irr_top), .isr_top(isr_top),
        .int_enable(int_enable), .task_prio(task_prio),
        .ack(ack),
        .present(irq_pending), .kind(kind), .vec_out(irq_vector),
        .take_cls(take_cls), .take_fixed(take_fixed)
    );

    assign irq_kind  = kind;
    assign irq_level = (kind == K_FIXED) ? trig_bits[irr_top] : 1'b0;

    assert_ack_moves_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && kind == K_FIXED) |=>
            (isr_bits[$past(irq_vector)] && !irr_bits[$past(irq_vector)]));

    assert_eoi_retires_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && isr_any && !take_fixed) |=> !isr_bits[$past(isr_top)]);

    assert_duplicate_keeps_trigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (queued_req && irr_bits[req_vector]) |=>
            (trig_bits[$past(req_vector)] == $past(trig_bits[req_vector])));

    assert_class_ack_spares_service_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_pending && kind != K_FIXED && !eoi) |=> $stable(isr_bits));
endmodule

// File: tb/irq_dispatch_test.sv
module irq_dispatch_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_vector = '0;
    logic [2:0] req_mode = '0;
    logic       req_level = 1'b0;
    logic       int_enable = 1'b0;
    logic [7:0] task_prio = '0;
    logic       ack = 1'b0;
    logic       eoi = 1'b0;
    logic       irq_pending;
    logic [2:0] irq_kind;
    logic [7:0] irq_vector;
    logic       irq_level;

    int checks = 0;
    int errors = 0;

    localparam logic [2:0] M_FIX = 3'd0, M_LOW = 3'd1, M_SMI = 3'd2, M_R3 = 3'd3,
                           M_NMI = 3'd4, M_INIT = 3'd5, M_R6 = 3'd6, M_EXT = 3'd7;
    localparam logic [2:0] KN = 3'd0, KS = 3'd1, KM = 3'd2, KI = 3'd3, KE = 3'd4, KF = 3'd5;

    always #4 clk = ~clk;

    irq_dispatch uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .req_mode(req_mode), .req_level(req_level), .int_enable(int_enable),
        .task_prio(task_prio), .ack(ack), .eoi(eoi), .irq_pending(irq_pending),
        .irq_kind(irq_kind), .irq_vector(irq_vector), .irq_level(irq_level)
    );

    task automatic check(input string tag, input logic ep, input logic [2:0] ek,
                         input logic [7:0] ev, input logic el);
        checks++;
        if (irq_pending !== ep || irq_kind !== ek || irq_vector !== ev || irq_level !== el) begin
            errors++;
            $display("FAIL %s: got pend=%0b kind=%0d vec=%02h lvl=%0b, expected pend=%0b kind=%0d vec=%02h lvl=%0b",
                     tag, irq_pending, irq_kind, irq_vector, irq_level, ep, ek, ev, el);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; int_enable = 1'b0; task_prio = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [7:0] v, input logic [2:0] m, input logic lvl);
        req_valid = 1'b1; req_vector = v; req_mode = m; req_level = lvl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1; @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse_eoi();
        eoi = 1'b1; @(negedge clk); eoi = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset state", 0, KN, 8'h00, 0);
        int_enable = 1'b1;
        check("R1 empty with enable", 0, KN, 8'h00, 0);
    endtask

    task automatic t_queue();
        do_reset(); int_enable = 1'b1;
        send(8'h41, M_FIX, 1);
        check("R2 fixed level", 1, KF, 8'h41, 1);
        send(8'h62, M_LOW, 0);
        check("R2 lowest edge highest", 1, KF, 8'h62, 0);
    endtask

    task automatic t_duplicate();
        do_reset(); int_enable = 1'b1;
        send(8'h33, M_FIX, 1);
        send(8'h33, M_FIX, 0);
        check("R3 duplicate keeps trigger", 1, KF, 8'h33, 1);
        pulse_ack();
        check("R3 single request bit", 0, KN, 8'h00, 0);
    endtask

    task automatic t_reserved();
        do_reset(); int_enable = 1'b1;
        send(8'h80, M_R3, 1);
        send(8'h90, M_R6, 0);
        check("R5 reserved ignored", 0, KN, 8'h00, 0);
    endtask

    task automatic t_order();
        do_reset(); int_enable = 1'b1;
        send(8'h90, M_FIX, 0);
        send(8'h20, M_EXT, 0);
        check("R8 ext over fixed", 1, KE, 8'h20, 0);
        send(8'h11, M_INIT, 0);
        check("R8 init over ext", 1, KI, 8'h11, 0);
        send(8'h02, M_NMI, 0);
        check("R8 nmi over init", 1, KM, 8'h02, 0);
        send(8'h05, M_SMI, 0);
        check("R8 smi first", 1, KS, 8'h05, 0);
        send(8'h07, M_SMI, 0);
        check("R4 repeat keeps vector", 1, KS, 8'h05, 0);
        pulse_ack();
        check("R11 smi taken", 1, KM, 8'h02, 0);
        pulse_ack();
        check("R11 nmi taken", 1, KI, 8'h11, 0);
        pulse_ack();
        check("R11 init taken", 1, KE, 8'h20, 0);
        pulse_ack();
        check("R11 service untouched", 1, KF, 8'h90, 0);
        pulse_ack();
        check("R9 fixed consumed", 0, KN, 8'h00, 0);
    endtask

    task automatic t_enable();
        do_reset(); int_enable = 1'b0;
        send(8'h70, M_FIX, 0);
        send(8'h21, M_EXT, 0);
        check("R6 masked when disabled", 0, KN, 8'h00, 0);
        send(8'h02, M_NMI, 0);
        check("R6 nmi ignores enable", 1, KM, 8'h02, 0);
        pulse_ack();
        check("R6 masked again", 0, KN, 8'h00, 0);
        int_enable = 1'b1; #1;
        check("R6 ext after enable", 1, KE, 8'h21, 0);
    endtask

    task automatic t_task_prio();
        do_reset(); int_enable = 1'b1; task_prio = 8'h70;
        send(8'h75, M_FIX, 0);
        check("R7 same class blocked", 0, KN, 8'h00, 0);
        task_prio = 8'h6F; #1;
        check("R7 higher class passes", 1, KF, 8'h75, 0);
        task_prio = 8'h80; #1;
        check("R7 lower class blocked", 0, KN, 8'h00, 0);
    endtask

    task automatic t_service();
        do_reset(); int_enable = 1'b1;
        send(8'h50, M_FIX, 0);
        pulse_ack();
        check("R9 after ack", 0, KN, 8'h00, 0);
        send(8'h45, M_FIX, 0);
        check("R9 below in-service blocked", 0, KN, 8'h00, 0);
        send(8'h58, M_FIX, 1);
        check("R9 above in-service", 1, KF, 8'h58, 1);
        pulse_ack();
        check("R9 two in service", 0, KN, 8'h00, 0);
        pulse_eoi();
        check("R10 top retired only", 0, KN, 8'h00, 0);
        pulse_eoi();
        check("R10 second retired", 1, KF, 8'h45, 0);
    endtask

    task automatic t_zero();
        do_reset(); int_enable = 1'b1;
        send(8'h00, M_FIX, 0);
        check("R13 vector zero silent", 0, KN, 8'h00, 0);
        send(8'h10, M_FIX, 0);
        check("R13 vector 0x10 shown", 1, KF, 8'h10, 0);
    endtask

    task automatic t_idle_ack();
        do_reset(); int_enable = 1'b1;
        pulse_ack();
        check("R12 idle ack", 0, KN, 8'h00, 0);
        int_enable = 1'b0;
        send(8'h30, M_FIX, 1);
        pulse_ack();
        int_enable = 1'b1; #1;
        check("R12 masked ack ignored", 1, KF, 8'h30, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_queue();
        t_duplicate();
        t_reserved();
        t_order();
        t_enable();
        t_task_prio();
        t_service();
        t_zero();
        t_idle_ack();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule